// File: doc/BRIEF.md
# Paired Page Permission Checker

This block finishes an address translation once a lookup has already found a translation entry. Each entry covers two neighbouring pages. It has one tag word that carries a page-size exponent, plus one page word for the even page and one for the odd page. The checker takes the entry, the virtual address, the kind of access and the current privilege level. It then picks the page word that applies and tests the access rights in a fixed order. It returns either a physical address with read, write and execute grants, or a fault code.

The page-size exponent comes from one of two places. A fully associative entry supplies it in its own tag field. A set-associative entry takes it from a global size input. Page words come in two formats. The wide format has no-read, no-execute and restricted-privilege bits. The narrow format has none of these, and its page number is cut at bit 31. A request is accepted on any cycle, and its result appears on the outputs one clock later.

Top module: `tlbchk_top`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. The result fields load only when a request is present and hold their value between requests.
- R2: When `req_setassoc` is 1, the page-size exponent is `req_glob_ps`. When it is 0, the exponent is `req_tag_ps`.
- R3: If the exponent is below 12 or above 30, the code is 6 (bad size). This wins over every other fault. The address is 0 and all grants are 0.
- R4: Virtual address bit number `ps` picks the page word: 1 selects `req_odd` and 0 selects `req_even`.
- R5: Page word bit 0 is the valid bit. If it is 0, the code is 1 (invalid), and this wins over all the access faults below.
- R6: Bit 62 is no-execute and gives code 2 on a fetch. Bit 61 is no-read and gives code 3 on a load. Access encodings are 0 fetch, 1 load, 2 store, and 3 is handled as a load.
- R7: Bits 3:2 hold the entry level and bit 63 is the restricted flag. With the flag at 0, code 4 is raised when `req_lvl` is greater than the entry level. With the flag at 1, code 4 is raised when the two levels differ. Code 4 wins over code 5.
- R8: Bit 1 is the dirty bit. A store to a word with dirty at 0 gives code 5.
- R9: With `req_fmt32` at 1, bits 63:61 count as 0 and only page-number bits 31:12 are used.
- R10: The page number sits in bits PA_W-1:12. The physical address is that number placed at bit 12 with bits 12 up to ps-1 cleared, ORed with the virtual address bits below ps.
- R11: On a match (code 0), read is granted, write equals dirty, and execute equals the inverse of no-execute. On any fault, all grants and the address are 0.
- R12: After reset, `rsp_valid` is 0, the code is 0, the address is 0 and all grants are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_setassoc | input | 1 | Entry came from the set-associative part |
| req_glob_ps | input | 6 | Global page-size exponent |
| req_tag_ps | input | 6 | Page-size exponent from the entry's tag word |
| req_fmt32 | input | 1 | Narrow page-word format |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_lvl | input | 2 | Current privilege level |
| req_even | input | 64 | Even page word |
| req_odd | input | 64 | Odd page word |
| req_vaddr | input | VA_W | Virtual address |
| rsp_valid | output | 1 | Result strobe |
| rsp_code | output | 3 | 0 match, 1 invalid, 2 no-exec, 3 no-read, 4 privilege, 5 clean store, 6 bad size |
| rsp_paddr | output | PA_W | Physical address |
| rsp_rd | output | 1 | Read granted |
| rsp_wr | output | 1 | Write granted |
| rsp_ex | output | 1 | Execute granted |

## Verification
Each result comes from a single register stage, so the outputs for a request driven before clock edge N are due right after edge N and stay until the next request. The bench drives each request on a falling edge and compares code, address and grants on the next falling edge, half a period after the capturing edge. The idle strobe is checked one cycle after the requests stop. The priority vectors set several fault conditions at the same time, so a fault order that has been swapped shows up as the wrong code.

// File: rtl/tlbchk_pkg.sv
package tlbchk_pkg;
    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_INVALID = 3'd1,
        FLT_NOEXEC  = 3'd2,
        FLT_NOREAD  = 3'd3,
        FLT_PRIV    = 3'd4,
        FLT_CLEAN   = 3'd5,
        FLT_BADSIZE = 3'd6
    } flt_e;

    localparam logic [1:0] ACC_FETCH = 2'd0;
    localparam logic [1:0] ACC_LOAD  = 2'd1;
    localparam logic [1:0] ACC_STORE = 2'd2;

    localparam int BIT_VALID = 0;
    localparam int BIT_DIRTY = 1;
    localparam int BIT_LVL   = 2;
    localparam int BIT_NORD  = 61;
    localparam int BIT_NOEX  = 62;
    localparam int BIT_RSTR  = 63;
    localparam int PPN_LSB   = 12;
    localparam int PS_MIN    = 12;
    localparam int PS_MAX    = 30;

    typedef struct packed {
        logic       valid;
        logic       dirty;
        logic [1:0] lvl;
        logic       nord;
        logic       noex;
        logic       rstr;
    } attr_t;
endpackage

// File: rtl/tlbchk_sel.sv
module tlbchk_sel
    import tlbchk_pkg::*;
#(
    parameter int VA_W = 48
) (
    input  logic            setassoc,
    input  logic [5:0]      glob_ps,
    input  logic [5:0]      tag_ps,
    input  logic [63:0]     even_word,
    input  logic [63:0]     odd_word,
    input  logic [VA_W-1:0] vaddr,
    output logic [5:0]      ps,
    output logic            ps_bad,
    output logic [63:0]     word
);
    logic [VA_W-1:0] va_shift;

    always_comb begin
        ps       = setassoc ? glob_ps : tag_ps;
        ps_bad   = (ps < 6'(PS_MIN)) || (ps > 6'(PS_MAX));
        va_shift = vaddr >> ps;
        word     = (!ps_bad && va_shift[0]) ? odd_word : even_word;
    end
endmodule

// File: rtl/tlbchk_rights.sv
module tlbchk_rights
    import tlbchk_pkg::*;
(
    input  logic [63:0] word,
    input  logic        fmt32,
    input  logic [1:0]  acc,
    input  logic [1:0]  cur_lvl,
    input  logic        ps_bad,
    output flt_e        code,
    output attr_t       attr
);
    logic is_fetch, is_store, is_load, lvl_fail;

    always_comb begin
        attr.valid = word[BIT_VALID];
        attr.dirty = word[BIT_DIRTY];
        attr.lvl   = word[BIT_LVL +: 2];
        attr.nord  = fmt32 ? 1'b0 : word[BIT_NORD];
        attr.noex  = fmt32 ? 1'b0 : word[BIT_NOEX];
        attr.rstr  = fmt32 ? 1'b0 : word[BIT_RSTR];

        is_fetch = (acc == ACC_FETCH);
        is_store = (acc == ACC_STORE);
        is_load  = !is_fetch && !is_store;
        lvl_fail = attr.rstr ? (cur_lvl != attr.lvl) : (cur_lvl > attr.lvl);

        if (ps_bad)                      code = FLT_BADSIZE;
        else if (!attr.valid)            code = FLT_INVALID;
        else if (is_fetch && attr.noex)  code = FLT_NOEXEC;
        else if (is_load && attr.nord)   code = FLT_NOREAD;
        else if (lvl_fail)               code = FLT_PRIV;
        else if (is_store && !attr.dirty) code = FLT_CLEAN;
        else                             code = FLT_NONE;
    end
endmodule

// File: rtl/tlbchk_xlate.sv
module tlbchk_xlate
    import tlbchk_pkg::*;
#(
    parameter int VA_W = 48,
    parameter int PA_W = 48
) (
    input  logic [63:0]     word,
    input  logic            fmt32,
    input  logic [5:0]      ps,
    input  logic [VA_W-1:0] vaddr,
    output logic [PA_W-1:0] paddr
);
    localparam int PPN_W = PA_W - PPN_LSB;

    logic [PA_W-1:0] va_ext, base, low_mask, narrow_mask;

    generate
        if (VA_W >= PA_W) begin : g_va_cut
            assign va_ext = vaddr[PA_W-1:0];
        end else begin : g_va_pad
            assign va_ext = {{(PA_W-VA_W){1'b0}}, vaddr};
        end
        if (PA_W > 32) begin : g_narrow
            assign narrow_mask = {{(PA_W-32){1'b0}}, 32'hFFFF_FFFF};
        end else begin : g_narrow_all
            assign narrow_mask = '1;
        end
    endgenerate

    always_comb begin
        base     = {word[PA_W-1:PPN_LSB], {PPN_LSB{1'b0}}};
        if (fmt32) base = base & narrow_mask;
        low_mask = (PA_W'(1) << ps) - PA_W'(1);
        paddr    = (base & ~low_mask) | (va_ext & low_mask);
    end

    logic unused_ok;
    assign unused_ok = &{1'b0, word[63:PA_W], PPN_W > 0};
endmodule

// File: rtl/tlbchk_top.sv
module tlbchk_top
    import tlbchk_pkg::*;
#(
    parameter int VA_W = 48,
    parameter int PA_W = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_setassoc,
    input  logic [5:0]      req_glob_ps,
    input  logic [5:0]      req_tag_ps,
    input  logic            req_fmt32,
    input  logic [1:0]      req_acc,
    input  logic [1:0]      req_lvl,
    input  logic [63:0]     req_even,
    input  logic [63:0]     req_odd,
    input  logic [VA_W-1:0] req_vaddr,
    output logic            rsp_valid,
    output logic [2:0]      rsp_code,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            rsp_rd,
    output logic            rsp_wr,
    output logic            rsp_ex
);
    typedef struct packed {
        logic            valid;
        flt_e            code;
        logic [PA_W-1:0] paddr;
        logic            rd;
        logic            wr;
        logic            ex;
    } rsp_t;

    logic [5:0]      ps;
    logic            ps_bad;
    logic [63:0]     word;
    flt_e            code;
    attr_t           attr;
    logic [PA_W-1:0] paddr;
    rsp_t            rsp_d, rsp_q;

    tlbchk_sel #(.VA_W(VA_W)) u_sel (
        .setassoc (req_setassoc),
        .glob_ps  (req_glob_ps),
        .tag_ps   (req_tag_ps),
        .even_word(req_even),
        .odd_word (req_odd),
        .vaddr    (req_vaddr),
        .ps       (ps),
        .ps_bad   (ps_bad),
        .word     (word)
    );

    tlbchk_rights u_rights (
        .word   (word),
        .fmt32  (req_fmt32),
        .acc    (req_acc),
        .cur_lvl(req_lvl),
        .ps_bad (ps_bad),
        .code   (code),
        .attr   (attr)
    );

    tlbchk_xlate #(.VA_W(VA_W), .PA_W(PA_W)) u_xlate (
        .word (word),
        .fmt32(req_fmt32),
        .ps   (ps),
        .vaddr(req_vaddr),
        .paddr(paddr)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.code = code;
            if (code == FLT_NONE) begin
                rsp_d.paddr = paddr;
                rsp_d.rd    = 1'b1;
                rsp_d.wr    = attr.dirty;
                rsp_d.ex    = !attr.noex;
            end else begin
                rsp_d.paddr = '0;
                rsp_d.rd    = 1'b0;
                rsp_d.wr    = 1'b0;
                rsp_d.ex    = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '{valid: 1'b0, code: FLT_NONE, paddr: '0, rd: 1'b0, wr: 1'b0, ex: 1'b0};
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_code  = rsp_q.code;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_rd    = rsp_q.rd;
    assign rsp_wr    = rsp_q.wr;
    assign rsp_ex    = rsp_q.ex;
endmodule

// File: rtl/tlbchk_chk.sv
module tlbchk_chk #(
    parameter int VA_W = 48,
    parameter int PA_W = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_setassoc,
    input logic [5:0]      req_glob_ps,
    input logic [5:0]      req_tag_ps,
    input logic            req_fmt32,
    input logic [1:0]      req_acc,
    input logic [1:0]      req_lvl,
    input logic [63:0]     req_even,
    input logic [63:0]     req_odd,
    input logic [VA_W-1:0] req_vaddr,
    input logic            rsp_valid,
    input logic [2:0]      rsp_code,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_rd,
    input logic            rsp_wr,
    input logic            rsp_ex
);
    assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_rsp_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_tag_size_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_setassoc && (req_tag_ps < 6'd12 || req_tag_ps > 6'd30))
        |=> (rsp_code == 3'd6));
    assert_glob_size_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_setassoc && (req_glob_ps < 6'd12 || req_glob_ps > 6'd30))
        |=> (rsp_code == 3'd6));
    assert_code_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_code <= 3'd6));
    assert_store_needs_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_acc == 2'd2) |=> (rsp_code != 3'd0 || rsp_wr));
    assert_narrow_no_xi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fmt32) |=> (rsp_code != 3'd2 && rsp_code != 3'd3));
    assert_fault_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != 3'd0) |-> (!rsp_rd && !rsp_wr && !rsp_ex && rsp_paddr == '0));
    assert_match_reads_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 3'd0) |-> rsp_rd);
endmodule

bind tlbchk_top tlbchk_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/sim_tlbchk_top.sv
module sim_tlbchk_top;
    localparam int VA_W = 48;
    localparam int PA_W = 48;

    typedef struct packed {
        logic [3:0]  rq;
        logic        sa;
        logic [5:0]  gps;
        logic [5:0]  tps;
        logic        f32;
        logic [1:0]  acc;
        logic [1:0]  lvl;
        logic [63:0] ev;
        logic [63:0] od;
        logic [47:0] va;
        logic [2:0]  code;
        logic [47:0] pa;
        logic        rd;
        logic        wr;
        logic        ex;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        // R10 basic match, even page, 4 KiB
        '{4'd10, 1'b0, 6'd0, 6'd12, 1'b0, 2'd1, 2'd3, 64'h0000_0000_1234_500F, 64'h0, 48'h4ABC, 3'd0, 48'h1234_5ABC, 1'b1, 1'b1, 1'b1},
        // R4 odd page chosen by address bit 12
        '{4'd4, 1'b0, 6'd0, 6'd12, 1'b0, 2'd1, 2'd0, 64'h0, 64'h0000_0000_0067_8003, 48'h5ABC, 3'd0, 48'h67_8ABC, 1'b1, 1'b1, 1'b1},
        // R5 invalid wins over no-execute
        '{4'd5, 1'b0, 6'd0, 6'd12, 1'b0, 2'd0, 2'd0, 64'h4000_0000_0000_0000, 64'h0, 48'h4ABC, 3'd1, 48'h0, 1'b0, 1'b0, 1'b0},
        // R6 fetch on no-execute
        '{4'd6, 1'b0, 6'd0, 6'd12, 1'b0, 2'd0, 2'd0, 64'h4000_0000_0000_0003, 64'h0, 48'h4ABC, 3'd2, 48'h0, 1'b0, 1'b0, 1'b0},
        // R6 load on no-read
        '{4'd6, 1'b0, 6'd0, 6'd12, 1'b0, 2'd1, 2'd0, 64'h2000_0000_0000_0003, 64'h0, 48'h4ABC, 3'd3, 48'h0, 1'b0, 1'b0, 1'b0},
        // R6 fetch on no-read word matches
        '{4'd6, 1'b0, 6'd0, 6'd12, 1'b0, 2'd0, 2'd0, 64'h2000_0000_0000_0003, 64'h0, 48'h4ABC, 3'd0, 48'hABC, 1'b1, 1'b1, 1'b1},
        // R7 level 2 above entry level 1
        '{4'd7, 1'b0, 6'd0, 6'd12, 1'b0, 2'd1, 2'd2, 64'h0000_0000_0000_0007, 64'h0, 48'h4ABC, 3'd4, 48'h0, 1'b0, 1'b0, 1'b0},
        // R7 level 0 below entry level 1
        '{4'd7, 1'b0, 6'd0, 6'd12, 1'b0, 2'd1, 2'd0, 64'h0000_0000_0000_0007, 64'h0, 48'h4ABC, 3'd0, 48'hABC, 1'b1, 1'b1, 1'b1},
        // R7 restricted: level 0 differs from 1
        '{4'd7, 1'b0, 6'd0, 6'd12, 1'b0, 2'd1, 2'd0, 64'h8000_0000_0000_0007, 64'h0, 48'h4ABC, 3'd4, 48'h0, 1'b0, 1'b0, 1'b0},
        // R7 restricted: equal levels match
        '{4'd7, 1'b0, 6'd0, 6'd12, 1'b0, 2'd1, 2'd1, 64'h8000_0000_0000_0007, 64'h0, 48'h4ABC, 3'd0, 48'hABC, 1'b1, 1'b1, 1'b1},
        // R8 store to clean page
        '{4'd8, 1'b0, 6'd0, 6'd12, 1'b0, 2'd2, 2'd0, 64'h0000_0000_0001_0001, 64'h0, 48'h4ABC, 3'd5, 48'h0, 1'b0, 1'b0, 1'b0},
        // R8 privilege wins over clean store
        '{4'd8, 1'b0, 6'd0, 6'd12, 1'b0, 2'd2, 2'd3, 64'h0000_0000_0001_0001, 64'h0, 48'h4ABC, 3'd4, 48'h0, 1'b0, 1'b0, 1'b0},
        // R11 clean no-exec page: read only
        '{4'd11, 1'b0, 6'd0, 6'd12, 1'b0, 2'd1, 2'd0, 64'h4000_0000_0001_0001, 64'h0, 48'h4ABC, 3'd0, 48'h1_0ABC, 1'b1, 1'b0, 1'b0},
        // R9 narrow format fetch: top bits ignored, PPN cut at 31
        '{4'd9, 1'b0, 6'd0, 6'd12, 1'b1, 2'd0, 2'd1, 64'hE000_00AB_CDEF_1009, 64'h0, 48'h4ABC, 3'd0, 48'hCDEF_1ABC, 1'b1, 1'b0, 1'b1},
        // R9 narrow format load
        '{4'd9, 1'b0, 6'd0, 6'd12, 1'b1, 2'd1, 2'd1, 64'hE000_00AB_CDEF_1009, 64'h0, 48'h4ABC, 3'd0, 48'hCDEF_1ABC, 1'b1, 1'b0, 1'b1},
        // R2 global size 14, software PPN bits cleared
        '{4'd2, 1'b1, 6'd14, 6'd0, 1'b0, 2'd1, 2'd0, 64'h0000_0000_00FF_F003, 64'h0, 48'h2_3456, 3'd0, 48'hFF_F456, 1'b1, 1'b1, 1'b1},
        // R3 tag size 11
        '{4'd3, 1'b0, 6'd0, 6'd11, 1'b0, 2'd1, 2'd0, 64'h3, 64'h3, 48'h4ABC, 3'd6, 48'h0, 1'b0, 1'b0, 1'b0},
        // R3 tag size 31, bad size over invalid
        '{4'd3, 1'b0, 6'd0, 6'd31, 1'b0, 2'd1, 2'd0, 64'h0, 64'h0, 48'h4ABC, 3'd6, 48'h0, 1'b0, 1'b0, 1'b0},
        // R2 tag size 13 used, global ignored
        '{4'd2, 1'b0, 6'd40, 6'd13, 1'b0, 2'd1, 2'd0, 64'h0000_0000_1234_500F, 64'h0, 48'h4ABC, 3'd0, 48'h1234_4ABC, 1'b1, 1'b1, 1'b1},
        // R10 largest size 30, odd page
        '{4'd10, 1'b0, 6'd0, 6'd30, 1'b0, 2'd1, 2'd0, 64'h0, 64'h0000_0000_4000_0003, 48'h4000_0123, 3'd0, 48'h4000_0123, 1'b1, 1'b1, 1'b1},
        // R3 global size 31
        '{4'd3, 1'b1, 6'd31, 6'd12, 1'b0, 2'd1, 2'd0, 64'h3, 64'h3, 48'h4ABC, 3'd6, 48'h0, 1'b0, 1'b0, 1'b0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0, req_setassoc = 1'b0, req_fmt32 = 1'b0;
    logic [5:0]      req_glob_ps = '0, req_tag_ps = '0;
    logic [1:0]      req_acc = '0, req_lvl = '0;
    logic [63:0]     req_even = '0, req_odd = '0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic            rsp_valid, rsp_rd, rsp_wr, rsp_ex;
    logic [2:0]      rsp_code;
    logic [PA_W-1:0] rsp_paddr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tlbchk_top #(.VA_W(VA_W), .PA_W(PA_W)) u0 (.*);

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(rsp_valid == 1'b0, "R12 valid", 64'(rsp_valid), 64'h0);
        chk(rsp_code == 3'd0 && rsp_paddr == '0, "R12 code/addr", {rsp_code, rsp_paddr}, 64'h0);
        chk({rsp_rd, rsp_wr, rsp_ex} == 3'b000, "R12 grants", 64'({rsp_rd, rsp_wr, rsp_ex}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            req_valid    = 1'b1;
            req_setassoc = TBL[i].sa;
            req_glob_ps  = TBL[i].gps;
            req_tag_ps   = TBL[i].tps;
            req_fmt32    = TBL[i].f32;
            req_acc      = TBL[i].acc;
            req_lvl      = TBL[i].lvl;
            req_even     = TBL[i].ev;
            req_odd      = TBL[i].od;
            req_vaddr    = TBL[i].va;
            @(negedge clk);
            chk(rsp_valid == 1'b1, "R1 valid", 64'(rsp_valid), 64'h1);
            chk(rsp_code == TBL[i].code, $sformatf("R%0d code vec %0d", TBL[i].rq, i), 64'(rsp_code), 64'(TBL[i].code));
            chk(rsp_paddr == TBL[i].pa, $sformatf("R%0d addr vec %0d", TBL[i].rq, i), 64'(rsp_paddr), 64'(TBL[i].pa));
            chk({rsp_rd, rsp_wr, rsp_ex} == {TBL[i].rd, TBL[i].wr, TBL[i].ex},
                $sformatf("R11 grants vec %0d", i), 64'({rsp_rd, rsp_wr, rsp_ex}), 64'({TBL[i].rd, TBL[i].wr, TBL[i].ex}));
        end
        // R1 idle: strobe drops, fields hold last result
        req_valid = 1'b0;
        req_even  = 64'h0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 idle valid", 64'(rsp_valid), 64'h0);
        chk(rsp_code == 3'd6, "R1 hold code", 64'(rsp_code), 64'h6);
        // R12 reset mid-run clears result
        req_valid = 1'b1; req_setassoc = 1'b0; req_tag_ps = 6'd12;
        req_acc = 2'd1; req_lvl = 2'd0; req_even = 64'h0000_0000_1234_500F; req_vaddr = 48'h4ABC;
        @(negedge clk);
        chk(rsp_paddr == 48'h1234_5ABC, "R10 addr before reset", 64'(rsp_paddr), 64'h1234_5ABC);
        req_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        chk(rsp_paddr == '0 && rsp_valid == 1'b0, "R12 async clear", 64'(rsp_paddr), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end
endmodule